// File: doc/BRIEF.md
# Microprocessor Bus Address Decoder

This block turns the upper address lines of an 8-bit processor with a 64 KB address space into chip selects for one RAM device, one ROM device and eight memory-mapped peripherals. The space is split unevenly: 44 KB of RAM at the bottom, a 4 KB peripheral window above it, and 16 KB of ROM at the top. The peripheral window is cut into eight 512-byte slots, and each slot has its own active-low select. The decode itself is purely combinational. RAM selection is qualified by the phase-2 bus clock so that no write lands before the address has settled. ROM and peripheral selects are left unqualified, because many bus peripherals need their select before phase 2 rises.

A small configuration register is loaded from spare parallel-port lines. It holds a ROM-off bit and two 2-bit bank numbers, one for RAM and one for ROM. The bank numbers drive the upper address lines of the two memories. With ROM switched off, the top 16 KB decodes as RAM, so nearly the whole space becomes writable memory.

Top module: `bus_addr_decoder`

## Requirements
- R1: With ROM enabled, pages 0xC..0xF of a_hi[6:3] (addresses 0xC000–0xFFFF) drive rom_oe_n low. rom_ce_n goes low there only when rd_nwr is 1 (read); on a write both rom_ce_n and ram_cs_n stay high.
- R2: Page 0xB (addresses 0xB000–0xBFFF) drives exactly io_sel_n[k] low, where k = a_hi[2:0] (address bits 11..9). Every other address leaves io_sel_n at all ones.
- R3: Pages 0x0..0xA (addresses 0x0000–0xAFFF) drive ram_cs_n low only while phi2 is 1. With phi2 at 0, ram_cs_n is high for every address.
- R4: ram_we_n equals rd_nwr at all times, for any address.
- R5: The values of rom_ce_n, rom_oe_n and io_sel_n do not depend on phi2.
- R6: The configuration register loads cfg_data on a rising clk edge while cfg_load is 1, and holds its value when cfg_load is 0. Its fields are bit 0 = ROM off, bits 2:1 = RAM bank, bits 4:3 = ROM bank. A synchronous active-high rst clears every field, and a loaded value appears on the outputs after that edge.
- R7: With the ROM-off bit set, pages 0xC..0xF decode as RAM: ram_cs_n follows phi2 there, and rom_ce_n and rom_oe_n stay high.
- R8: ram_bank and rom_bank always show the RAM and ROM bank fields held in the register, whatever the address.
- R9: For every combination of address, rd_nwr and phi2, at most one of ram_cs_n, rom_ce_n and the eight io_sel_n lines is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset of the configuration register |
| cfg_load | input | 1 | Load strobe for the configuration register |
| cfg_data | input | 5 | Configuration value: bit 0 ROM off, bits 2:1 RAM bank, bits 4:3 ROM bank |
| a_hi | input | 7 | Address bits 15..9 |
| rd_nwr | input | 1 | Bus direction, 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 bus clock |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_bank | output | 2 | Upper RAM address lines from the RAM bank field |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_bank | output | 2 | Upper ROM address lines from the ROM bank field |
| io_sel_n | output | 8 | Peripheral slot selects, active low |

## Verification
Every select and the write enable is due in the same cycle as the address, direction and phase-2 inputs that produce it. The bench drives these inputs just after the falling clock edge and compares them with its model two nanoseconds later, before the next rising edge. The bank outputs are due one rising edge after a load strobe, so the bench checks them once before that edge to show that nothing has moved yet and again after the edge to see the new value. All 512 combinations of address page, slot, direction and phase 2 are swept under each of four register settings.

// File: rtl/bus_addr_decoder_pkg.sv
package bus_addr_decoder_pkg;

    localparam int PAGE_W    = 4;
    localparam int SLOT_W    = 3;
    localparam int ADDR_HI_W = PAGE_W + SLOT_W;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int BANK_W    = 2;
    localparam int CFG_W     = 2 * BANK_W + 1;

    localparam logic [PAGE_W-1:0] IO_PAGE        = 4'hB;
    localparam logic [PAGE_W-1:0] ROM_FIRST_PAGE = 4'hC;

    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_IO  = 2'd1,
        RGN_ROM = 2'd2
    } region_e;

    typedef struct packed {
        logic [BANK_W-1:0] rom_bank;
        logic [BANK_W-1:0] ram_bank;
        logic              rom_off;
    } bank_cfg_t;

    typedef struct packed {
        logic ram;
        logic io;
        logic rom;
    } region_hit_t;

    function automatic region_e classify(input logic [PAGE_W-1:0] pg,
                                         input logic rom_off);
        if (pg == IO_PAGE)
            return RGN_IO;
        if ((pg >= ROM_FIRST_PAGE) && !rom_off)
            return RGN_ROM;
        return RGN_RAM;
    endfunction

endpackage

// File: rtl/addr_dec_bank_reg.sv
module addr_dec_bank_reg
    import bus_addr_decoder_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] wdata,
    output bank_cfg_t        cfg
);

    bank_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= bank_cfg_t'(wdata);
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/addr_dec_region.sv
module addr_dec_region
    import bus_addr_decoder_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  logic              rom_off,
    output region_hit_t       hit
);

    region_e rgn;

    always_comb begin
        rgn     = classify(page, rom_off);
        hit     = '0;
        unique case (rgn)
            RGN_IO:  hit.io  = 1'b1;
            RGN_ROM: hit.rom = 1'b1;
            default: hit.ram = 1'b1;
        endcase
    end

endmodule

// File: rtl/addr_dec_slot_sel.sv
module addr_dec_slot_sel
    import bus_addr_decoder_pkg::*;
(
    input  logic                 en,
    input  logic [SLOT_W-1:0]    slot,
    output logic [NUM_SLOTS-1:0] sel_n
);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign sel_n[k] = !(en && (slot == SLOT_W'(k)));
    end

endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import bus_addr_decoder_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_load,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic [ADDR_HI_W-1:0] a_hi,
    input  logic                 rd_nwr,
    input  logic                 phi2,
    output logic                 ram_cs_n,
    output logic                 ram_we_n,
    output logic [BANK_W-1:0]    ram_bank,
    output logic                 rom_ce_n,
    output logic                 rom_oe_n,
    output logic [BANK_W-1:0]    rom_bank,
    output logic [NUM_SLOTS-1:0] io_sel_n
);

    bank_cfg_t   cfg;
    region_hit_t hit;
    logic [PAGE_W-1:0] page;
    logic [SLOT_W-1:0] slot;
    logic              a14;

    assign page = a_hi[ADDR_HI_W-1 -: PAGE_W];
    assign slot = a_hi[SLOT_W-1:0];
    assign a14  = a_hi[ADDR_HI_W-2];

    addr_dec_bank_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_load),
        .wdata (cfg_data),
        .cfg   (cfg)
    );

    addr_dec_region u_region (
        .page    (page),
        .rom_off (cfg.rom_off),
        .hit     (hit)
    );

    addr_dec_slot_sel u_slots (
        .en    (hit.io),
        .slot  (slot),
        .sel_n (io_sel_n)
    );

    // RAM select is qualified by phase 2; ROM and I/O are not.
    assign ram_cs_n = !(hit.ram && phi2);
    assign ram_we_n = rd_nwr;
    assign rom_oe_n = !hit.rom;
    assign rom_ce_n = !(hit.rom && a14 && rd_nwr);
    assign ram_bank = cfg.ram_bank;
    assign rom_bank = cfg.rom_bank;

endmodule

// File: rtl/bus_addr_decoder_chk.sv
module bus_addr_decoder_chk
    import bus_addr_decoder_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_load,
    input logic [CFG_W-1:0]     cfg_data,
    input logic [ADDR_HI_W-1:0] a_hi,
    input logic                 rd_nwr,
    input logic                 phi2,
    input logic                 ram_cs_n,
    input logic                 rom_ce_n,
    input logic                 rom_oe_n,
    input logic [NUM_SLOTS-1:0] io_sel_n,
    input logic [BANK_W-1:0]    ram_bank,
    input logic [BANK_W-1:0]    rom_bank
);

    a_r9_single_select: assert property (@(posedge clk) disable iff (rst)
        $countones({~ram_cs_n, ~rom_ce_n, ~io_sel_n}) <= 1);

    a_r3_ram_needs_phi2: assert property (@(posedge clk) disable iff (rst)
        !ram_cs_n |-> phi2);

    a_r2_io_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~io_sel_n));

    a_r2_io_in_window: assert property (@(posedge clk) disable iff (rst)
        (io_sel_n != '1) |-> (a_hi[ADDR_HI_W-1 -: PAGE_W] == IO_PAGE));

    a_r1_rom_read_only: assert property (@(posedge clk) disable iff (rst)
        !rom_ce_n |-> (rd_nwr && !rom_oe_n));

    a_r6_load_visible: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> ({rom_bank, ram_bank} == $past(cfg_data[CFG_W-1:1])));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> ($stable(ram_bank) && $stable(rom_bank)));

    a_r7_rom_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && cfg_data[0]) |=> (rom_oe_n && rom_ce_n));

endmodule

bind bus_addr_decoder bus_addr_decoder_chk u_chk (.*);

// File: tb/bus_addr_decoder_test.sv
module bus_addr_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [4:0] cfg_data = '0;
    logic [6:0] a_hi = '0;
    logic       rd_nwr = 1'b1;
    logic       phi2 = 1'b0;
    logic       ram_cs_n, ram_we_n, rom_ce_n, rom_oe_n;
    logic [1:0] ram_bank, rom_bank;
    logic [7:0] io_sel_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // model state of the configuration register
    int m_off = 0, m_ram = 0, m_rom = 0;

    always #4 clk = ~clk;   // 125 MHz

    bus_addr_decoder uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_data(cfg_data),
        .a_hi(a_hi), .rd_nwr(rd_nwr), .phi2(phi2),
        .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_bank(ram_bank),
        .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_bank(rom_bank),
        .io_sel_n(io_sel_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (a_hi=%0h rd=%0b phi2=%0b)",
                     tag, act, exp, a_hi, rd_nwr, phi2);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    // load the configuration register and track it in the model
    task automatic load_cfg(input int off, input int ram, input int rom);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_data = 5'((rom << 3) | (ram << 1) | off);
        #2;
        chk("R6 before edge ram_bank", ram_bank, m_ram);
        chk("R6 before edge rom_bank", rom_bank, m_rom);
        @(posedge clk);
        m_off = off; m_ram = ram; m_rom = rom;
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_data = 5'(~cfg_data);   // ignored while cfg_load is low
        #2;
        chk("R6 loaded ram_bank", ram_bank, m_ram);
        chk("R6 loaded rom_bank", rom_bank, m_rom);
        @(negedge clk);
        #2;
        chk("R6 held ram_bank", ram_bank, m_ram);
        chk("R6 held rom_bank", rom_bank, m_rom);
    endtask

    task automatic sweep();
        for (int a = 0; a < 128; a++) begin
            for (int rw = 0; rw < 2; rw++) begin
                for (int ph = 0; ph < 2; ph++) begin
                    int pg, sl, is_rom, is_io, is_ram, e_io, e_cnt;
                    @(negedge clk);
                    a_hi = 7'(a); rd_nwr = rw[0]; phi2 = ph[0];
                    #2;
                    pg = a / 8; sl = a % 8;
                    is_io  = (pg == 11) ? 1 : 0;
                    is_rom = (pg >= 12 && m_off == 0) ? 1 : 0;
                    is_ram = (!is_io && !is_rom) ? 1 : 0;
                    e_io   = is_io ? (8'hFF ^ (1 << sl)) : 8'hFF;
                    if (pg >= 12 && m_off != 0)
                        chk("R7 ram_cs_n", ram_cs_n, (ph == 1) ? 0 : 1);
                    else
                        chk("R3 ram_cs_n", ram_cs_n, (is_ram && ph == 1) ? 0 : 1);
                    chk("R4 ram_we_n", ram_we_n, rw);
                    chk(ph == 1 ? "R1 rom_oe_n" : "R5 rom_oe_n", rom_oe_n, is_rom ? 0 : 1);
                    chk(ph == 1 ? "R1 rom_ce_n" : "R5 rom_ce_n", rom_ce_n,
                        (is_rom && rw == 1) ? 0 : 1);
                    chk(ph == 1 ? "R2 io_sel_n" : "R5 io_sel_n", io_sel_n, e_io);
                    chk("R8 ram_bank", ram_bank, m_ram);
                    chk("R8 rom_bank", rom_bank, m_rom);
                    e_cnt = $countones({~ram_cs_n, ~rom_ce_n, ~io_sel_n});
                    chk("R9 select count le 1", (e_cnt <= 1) ? 1 : 0, 1);
                end
            end
        end
    endtask

    initial begin
        cfg_data = 5'h1F;
        cfg_load = 1'b1;            // ignored under reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cfg_load = 1'b0;
        #2;
        chk("R6 reset ram_bank", ram_bank, 0);
        chk("R6 reset rom_bank", rom_bank, 0);
        a_hi = 7'h60; phi2 = 1'b1; rd_nwr = 1'b1;   // page 0xC, ROM on after reset
        #1;
        chk("R6 reset rom enabled rom_oe_n", rom_oe_n, 0);
        sweep();
        load_cfg(0, 2, 1);
        sweep();
        load_cfg(1, 3, 3);
        sweep();
        load_cfg(0, 1, 2);
        sweep();
        done = 1;
        finish_run();
    end

endmodule